// File: doc/BRIEF.md
# Cascaded Power-Good Output Sequencer

This block releases four active-low power-good outputs one after another once the external pass switch is fully on. A level from a gate-voltage comparator is caught in a sticky latch. The latch holds until reset or a fault. Once it is set, output 1 asserts on the next clock. Outputs 2, 3 and 4 then follow, each one delay period after the one before it. A 3-bit code selects the delay period from an eight-entry table of clock-cycle counts, which is supplied as a parameter. The code is captured once, when the sequence starts.

Four enable inputs decide whether each output pin is driven or left at high impedance. The enables are nested: enable A governs outputs 2 to 4, enable B governs outputs 3 and 4, and enable C governs output 4 alone. A separate enable governs output 1. The enables act only on the output-enable bits. The sequence timer keeps running underneath, so an output that is enabled again shows the state it has already reached. A fault input clears the latch and the sequence, and while it is held it forces every output high and driven. All pins are plain control and status levels, so there is no valid/ready handshake.

Top module: `pg_sequencer`

## Requirements
- R1: While reset is held, every `pg_drv_o` bit is 1 (deasserted) and `seq_done_o` is 0.
- R2: The gate-good latch sets on the first clock edge where `gate_ok_i` is 1 and `fault_i` is 0. It stays set after `gate_ok_i` drops, until reset or fault.
- R3: No `pg_drv_o` bit is 0 while the gate-good latch is clear.
- R4: Bit i of `pg_drv_o` is output i+1, and 0 means asserted. Output 1 asserts one clock after the latch sets. Each later output asserts D clocks after the previous one, where D is entry `dly_sel_i` of the delay table (entry 0 in the least significant field). Outputs never assert out of order.
- R5: `dly_sel_i` is sampled on the edge where output 1 asserts. Later changes to it do not alter the running sequence.
- R6: `pg_oe_o[1]` follows `en_a_i`, and enable A is also required by outputs 3 and 4 (1 = driven, 0 = high impedance).
- R7: `pg_oe_o[2]` is `en_a_i & en_b_i`.
- R8: `pg_oe_o[3]` is `en_a_i & en_b_i & en_c_i`.
- R9: `pg_oe_o[0]` follows `pg1_en_i` and does not depend on the cascaded enables.
- R10: The enables never change `pg_drv_o` or the sequence timing.
- R11: While `fault_i` is 1, `pg_drv_o` and `pg_oe_o` are all 1s. The edge that sees the fault clears the latch and the sequence, and output 1 asserts only after the latch is set again.
- R12: `seq_done_o` is 1 exactly when all four outputs are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_ok_i | input | 1 | Gate-voltage-good comparator level |
| dly_sel_i | input | SEL_W | Delay table index |
| en_a_i | input | 1 | Enable for outputs 2 to 4 |
| en_b_i | input | 1 | Enable for outputs 3 and 4 |
| en_c_i | input | 1 | Enable for output 4 |
| pg1_en_i | input | 1 | Enable for output 1 |
| fault_i | input | 1 | Global fault kill |
| pg_drv_o | output | 4 | Active-low power-good drive values |
| pg_oe_o | output | 4 | Output enables, 1 = driven |
| seq_done_o | output | 1 | All four outputs asserted |

## Verification
The fault kill and a step advance can land on the same clock edge. A fault arriving as the gate-good level rises competes in the same way. The bench raises `fault_i` in the cycle just before output 2 is due and expects every output forced high and driven at once. It then expects no advance on that edge, an idle block after release while the gate level is low, and a fresh sequence timed from the next latch set. Enable changes are also applied every cycle during the timed sweeps, and the drive values are expected to follow the schedule computed from the delay code alone.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;
  localparam int unsigned NUM_PG = 4;
  localparam int unsigned STEP_W = $clog2(NUM_PG + 1);
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/pg_gate_latch.sv
module pg_gate_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic gate_ok_i,
  output logic latched_o
);
  logic latched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latched_q <= 1'b0;
    else if (fault_i)   latched_q <= 1'b0;
    else if (gate_ok_i) latched_q <= 1'b1;
  end

  assign latched_o = latched_q;

  // R2
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && !fault_i) |=> latched_q);
  // R11
  latch_fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> !latched_q);
endmodule

// File: rtl/pg_step_timer.sv
module pg_step_timer
  import pg_seq_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DLY_W = 24,
  parameter logic [(1<<SEL_W)*DLY_W-1:0] DLY_TABLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] dly_sel_i,
  output step_t            step_o
);
  step_t            step_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W:0]   cnt_nxt;
  logic             period_end;

  assign cnt_nxt    = {1'b0, cnt_q} + 1'b1;
  assign period_end = cnt_nxt >= {1'b0, dly_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      cnt_q  <= '0;
      dly_q  <= '0;
    end else if (fault_i) begin
      step_q <= '0;
      cnt_q  <= '0;
    end else if (step_q == '0) begin
      if (start_i) begin
        step_q <= step_t'(1);
        cnt_q  <= '0;
        dly_q  <= DLY_TABLE[dly_sel_i*DLY_W +: DLY_W];
      end
    end else if (int'(step_q) < NUM_PG) begin
      if (period_end) begin
        step_q <= step_q + step_t'(1);
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt[DLY_W-1:0];
      end
    end
  end

  assign step_o = step_q;

  // R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> (step_q == $past(step_q) || step_q == $past(step_q) + step_t'(1)));
  // R3
  step_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != '0) |-> start_i);
  // R5
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != '0 && !fault_i) |=> $stable(dly_q));
endmodule

// File: rtl/pg_out_stage.sv
module pg_out_stage
  import pg_seq_pkg::*;
(
  input  step_t             step_i,
  input  logic              fault_i,
  input  logic              pg1_en_i,
  input  logic [NUM_PG-2:0] en_chain_i,
  output logic [NUM_PG-1:0] drv_o,
  output logic [NUM_PG-1:0] oe_o,
  output logic              done_o
);
  logic [NUM_PG-1:0] gate_and;

  assign gate_and[0] = pg1_en_i;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PG; gi++) begin : g_pin
      if (gi >= 1) begin : g_cascade
        if (gi == 1) begin : g_first
          assign gate_and[gi] = en_chain_i[0];
        end else begin : g_rest
          assign gate_and[gi] = gate_and[gi-1] & en_chain_i[gi-1];
        end
      end
      assign drv_o[gi] = fault_i | ~(int'(step_i) > gi);
      assign oe_o[gi]  = fault_i | gate_and[gi];
    end
  endgenerate

  assign done_o = !fault_i && (int'(step_i) == NUM_PG);
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
  import pg_seq_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DLY_W = 24,
  parameter logic [(1<<SEL_W)*DLY_W-1:0] DLY_TABLE = {
    24'd16000000, 24'd8000000, 24'd4000000, 24'd1000000,
    24'd500000,   24'd100000,  24'd25000,   24'd5000}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_ok_i,
  input  logic [SEL_W-1:0] dly_sel_i,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             en_c_i,
  input  logic             pg1_en_i,
  input  logic             fault_i,
  output logic [3:0]       pg_drv_o,
  output logic [3:0]       pg_oe_o,
  output logic             seq_done_o
);
  logic  latched;
  step_t step;

  pg_gate_latch i_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (fault_i),
    .gate_ok_i (gate_ok_i),
    .latched_o (latched)
  );

  pg_step_timer #(
    .SEL_W     (SEL_W),
    .DLY_W     (DLY_W),
    .DLY_TABLE (DLY_TABLE)
  ) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_i   (fault_i),
    .start_i   (latched),
    .dly_sel_i (dly_sel_i),
    .step_o    (step)
  );

  pg_out_stage i_out (
    .step_i     (step),
    .fault_i    (fault_i),
    .pg1_en_i   (pg1_en_i),
    .en_chain_i ({en_c_i, en_b_i, en_a_i}),
    .drv_o      (pg_drv_o),
    .oe_o       (pg_oe_o),
    .done_o     (seq_done_o)
  );

  // R3
  no_early_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latched |-> (pg_drv_o == 4'hF));
  // R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pg_drv_o) & ((~pg_drv_o) + 4'd1)) == 4'd0);
  // R11
  fault_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |-> (pg_drv_o == 4'hF && pg_oe_o == 4'hF));
  // R8
  nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && pg_oe_o[3]) |-> (pg_oe_o[2] && pg_oe_o[1]));
  // R12
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (pg_drv_o == 4'h0));
endmodule

// File: tb/test_pg_sequencer.sv
module test_pg_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_ok = 1'b0;
  logic [2:0] dly_sel = 3'd0;
  logic       en_a = 1'b1, en_b = 1'b1, en_c = 1'b1, pg1_en = 1'b1;
  logic       fault = 1'b0;
  logic [3:0] drv, oe;
  logic       done;
  int         n_tests = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  pg_sequencer #(
    .SEL_W (3),
    .DLY_W (8),
    .DLY_TABLE ({8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2})
  ) i_pg_sequencer (
    .clk (clk), .rst_n (rst_n), .gate_ok_i (gate_ok), .dly_sel_i (dly_sel),
    .en_a_i (en_a), .en_b_i (en_b), .en_c_i (en_c), .pg1_en_i (pg1_en),
    .fault_i (fault), .pg_drv_o (drv), .pg_oe_o (oe), .seq_done_o (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_drv(input int n);
    return 4'hF << n;
  endfunction

  function automatic logic [3:0] exp_oe(input logic p, a, b, c);
    return {a & b & c, a & b, a, p};
  endfunction

  task automatic do_reset;
    rst_n = 1'b0; gate_ok = 1'b0; fault = 1'b0;
    en_a = 1'b1; en_b = 1'b1; en_c = 1'b1; pg1_en = 1'b1;
    tick; tick;
    rst_n = 1'b1;
    tick;
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    tick;
    chk(drv == 4'hF, "R1 drv in reset", drv, 4'hF);
    chk(done == 1'b0, "R1 done in reset", done, 0);

    // R4 R5 R2 R6-R10 R12: timed sweep over every delay code
    for (int code = 0; code < 8; code++) begin
      int d;
      d = code + 2;
      do_reset;
      chk(drv == 4'hF, "R3 idle before gate", drv, 4'hF);
      dly_sel = 3'(code);
      gate_ok = 1'b1;
      for (int e = 0; e <= 4 * d + 3; e++) begin
        int n;
        logic [3:0] pat;
        tick;
        n = (e == 0) ? 0 : 1 + (e - 1) / d;
        if (n > 4) n = 4;
        chk(drv == exp_drv(n), "R4 step timing", drv, exp_drv(n));
        chk(done == (n == 4), "R12 done flag", done, n == 4);
        chk(oe == exp_oe(pg1_en, en_a, en_b, en_c), "R6 R7 R8 R9 nested enables",
            oe, exp_oe(pg1_en, en_a, en_b, en_c));
        if (e == 0 && code[0]) gate_ok = 1'b0;      // R2 sticky latch
        if (e == 2) dly_sel = 3'(7 - code);          // R5 captured code
        pat = 4'((e * 5 + code) & 15);               // R10 enables vary
        {pg1_en, en_a, en_b, en_c} = pat;
      end
    end

    // R6 R7 R8 R9 exhaustive enable combos with sequence complete
    for (int p = 0; p < 16; p++) begin
      {pg1_en, en_a, en_b, en_c} = 4'(p);
      #1;
      chk(oe == exp_oe(pg1_en, en_a, en_b, en_c), "R9 R6 R7 R8 enable combo",
          oe, exp_oe(pg1_en, en_a, en_b, en_c));
      chk(drv == 4'h0, "R10 drv unaffected", drv, 0);
    end

    // R11 fault on the edge where output 2 is due (D = 3)
    do_reset;
    dly_sel = 3'd1;
    gate_ok = 1'b1;
    for (int e = 0; e < 4; e++) tick;
    chk(drv == 4'hE, "R4 pre-fault state", drv, 4'hE);
    en_a = 1'b0; pg1_en = 1'b0;
    fault = 1'b1;
    #1;
    chk(drv == 4'hF, "R11 fault forces drv", drv, 4'hF);
    chk(oe == 4'hF, "R11 fault forces oe", oe, 4'hF);
    tick;
    chk(drv == 4'hF && done == 1'b0, "R11 held in fault", drv, 4'hF);
    fault = 1'b0; gate_ok = 1'b0; en_a = 1'b1; pg1_en = 1'b1;
    for (int e = 0; e < 3; e++) begin
      tick;
      chk(drv == 4'hF, "R11 latch cleared", drv, 4'hF);
    end
    gate_ok = 1'b1;
    tick;
    chk(drv == 4'hF, "R3 latch edge only", drv, 4'hF);
    tick;
    chk(drv == 4'hE, "R11 restart output 1", drv, 4'hE);
    for (int e = 0; e < 3; e++) tick;
    chk(drv == 4'hC, "R11 restart output 2", drv, 4'hC);

    // R2 fault and gate rise in the same cycle: fault wins
    do_reset;
    gate_ok = 1'b1; fault = 1'b1;
    tick;
    fault = 1'b0; gate_ok = 1'b0;
    tick; tick;
    chk(drv == 4'hF, "R2 fault beats gate", drv, 4'hF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule